// File: doc/BRIEF.md
# Floppy Controller Register File with Status and Interrupt Logic

This block is the processor-facing register bank of a single-density floppy disk controller. A host reaches eight byte-wide locations through a 3-bit offset with separate read and write strobes. It holds the command word, a 4-bit interrupt status word, two status words, and the track, sector, count, setup and CRC-control values. The command engine that moves sectors is outside the block. It is reached only through a start pulse, a delayed continuation pulse, a completion pulse and inputs that set status or error bits.

Several reads have side effects. Reading interrupt status clears its event bits. Reading the error status clears everything except the missing-data-mark flag. Reading main status samples the drive lines (ready, track zero, write protect, index) into that word. The interrupt request is always derived from the registered status and the two mask bits held in the command word. A controller-level soft reset clears only selected fields. A full asynchronous reset clears everything.

Top module: `fdc_regfile`

## Requirements
- R1: Offsets 1, 5 and 7 keep only the low 7 bits of a written byte (track, count, logical track). Offset 6 keeps 2 bits (CRC control). Each of these offsets reads back its stored value. A write to offset 4 keeps 5 bits, which appear on `sect_addr`. Offset 0 always reads 0.
- R2: Interrupt status bit 3 is 1 exactly when error status (read at offset 4) is non-zero and command bit 6 is 0. It follows every change of either.
- R3: `irq` is high whenever interrupt status bit 2 is set. Interrupt status bits 0, 1 and 3 raise `irq` only while command bit 7 is 0.
- R4: A read of interrupt status (offset 2) returns its value, then clears bits 0 to 2 and leaves bit 3 governed by R2.
- R5: A read of error status (offset 4) returns its value, then clears all bits except bit 2.
- R6: On `eng_done`, if the command code (command bits 3:0) is 2 or 3, interrupt status bit 1 is set; otherwise bit 0 is set. Main status bit 7 (busy) is cleared and the command code becomes 0. `eng_done` is ignored in a cycle with a command write.
- R7: A command write (offset 2) clears main status bits 7 and 0. Codes 2 to 7, 12 and 13 then set busy and pulse `cmd_start` for one cycle. Codes 4 to 7, 12 and 13 also clear main status bits 5 and 1 and error status bit 2.
- R8: A read of main status (offset 3) shows drive ready in bit 2, track zero in bit 3, write protect in bit 4 and index in bit 6. The latched bits 0, 1, 5 and 7 are unchanged.
- R9: `soft_rst` zeroes the command code, interrupt status and sector address. It ANDs main status with 0x5C and error status with 0x20, and cancels a pending continuation.
- R10: `cont_pulse` is high for one cycle, exactly N = (setup+1)·2^DLY_SHIFT cycles after the edge that takes a busy-setting command. Setup is the byte written at offset 3. A new such command restarts the count. `eng_done` or `soft_rst` cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| soft_rst | input | 1 | Controller reset with field-selective clearing |
| rd_en | input | 1 | Read strobe; side effects at the clock edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| drv_ready | input | 1 | Drive ready line |
| drv_trk0 | input | 1 | Head at track zero line |
| drv_wprot | input | 1 | Write protect line |
| drv_index | input | 1 | Index hole line |
| eng_sense | input | 1 | Engine sets interrupt status bit 2 |
| eng_sta_set | input | 8 | Engine sets main status bits (only bits 5, 1, 0 accepted) |
| eng_stb_set | input | 8 | Engine sets error status bits |
| eng_done | input | 1 | Engine command completion pulse |
| sect_addr | output | 5 | Stored sector address |
| cmd_start | output | 1 | One-cycle pulse after a busy-setting command write |
| cont_pulse | output | 1 | Delayed continuation pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is interrupt status bit 3 being set while masked and then cleared by the mask. The stimulus writes a command with bit 7 set and injects an error bit. It shows that `irq` stays low until the unmaskable sense bit arrives. It then rewrites the command with bit 6 set and shows bit 3 dropping while error status is still non-zero. Completion selection is checked twice in a row: after a seek completes, a second completion must set bit 0, which shows that the code was zeroed. The continuation timer is checked for restart with a second command in mid-count and for cancellation by completion. Each case watches every cycle of the window.

// File: rtl/fdc_reg_pkg.sv
package fdc_reg_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned TRK_W  = 7;
    localparam int unsigned SECT_W = 5;
    localparam int unsigned CRC_W  = 2;
    localparam int unsigned ISR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DATA  = 3'd0,
        OFF_TRACK = 3'd1,
        OFF_CMD   = 3'd2,
        OFF_SETUP = 3'd3,
        OFF_SECT  = 3'd4,
        OFF_COUNT = 3'd5,
        OFF_CRC   = 3'd6,
        OFF_LTRK  = 3'd7
    } reg_off_e;

    // main status bit positions
    localparam int unsigned STA_DREQ  = 0;
    localparam int unsigned STA_DDM   = 1;
    localparam int unsigned STA_RDY   = 2;
    localparam int unsigned STA_TRK0  = 3;
    localparam int unsigned STA_WP    = 4;
    localparam int unsigned STA_TNE   = 5;
    localparam int unsigned STA_IDX   = 6;
    localparam int unsigned STA_BUSY  = 7;

    localparam logic [DATA_W-1:0] STA_ENG_MASK  = 8'h23;
    localparam logic [DATA_W-1:0] STA_SRST_KEEP = 8'h5C;
    localparam logic [DATA_W-1:0] STB_SRST_KEEP = 8'h20;
    localparam logic [DATA_W-1:0] STB_RD_KEEP   = 8'h04;

    typedef struct packed {
        logic [TRK_W-1:0]  trk;
        logic [DATA_W-1:0] cmd;
        logic [ISR_W-1:0]  isr;
        logic [DATA_W-1:0] setup;
        logic [DATA_W-1:0] sta;
        logic [DATA_W-1:0] stb;
        logic [SECT_W-1:0] sect;
        logic [TRK_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic [TRK_W-1:0]  ltrk;
    } regs_t;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode (
    input  logic [3:0] code,
    output logic       sets_busy,
    output logic       is_xfer,
    output logic       is_seek
);
    always_comb begin
        is_seek   = (code == 4'h2) || (code == 4'h3);
        is_xfer   = ((code >= 4'h4) && (code <= 4'h7)) ||
                    (code == 4'hC) || (code == 4'hD);
        sets_busy = is_seek || is_xfer;
    end
endmodule

// File: rtl/fdc_delay_timer.sv
module fdc_delay_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr,
    input  logic [CNT_W-1:0] load,
    output logic             pulse
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        t_d.pulse = 1'b0;
        if (start) begin
            t_d.active = 1'b1;
            t_d.cnt    = load;
        end else if (clr) begin
            t_d.active = 1'b0;
        end else if (t_q.active) begin
            if (t_q.cnt == '0) begin
                t_d.pulse  = 1'b1;
                t_d.active = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pulse = t_q.pulse;

    AST_PULSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(t_q.active)); // R10
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R10
endmodule

// File: rtl/fdc_irq_gen.sv
module fdc_irq_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] isr,
    input  logic       mask,
    output logic       irq
);
    always_comb begin
        irq = isr[2] | (~mask & (isr[3] | isr[1] | isr[0]));
    end

    AST_SENSE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        isr[2] |-> irq); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !isr[2]) |-> !irq); // R3
endmodule

// File: rtl/fdc_regfile.sv
module fdc_regfile
    import fdc_reg_pkg::*;
#(
    parameter int unsigned DLY_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              drv_ready,
    input  logic              drv_trk0,
    input  logic              drv_wprot,
    input  logic              drv_index,
    input  logic              eng_sense,
    input  logic [DATA_W-1:0] eng_sta_set,
    input  logic [DATA_W-1:0] eng_stb_set,
    input  logic              eng_done,
    output logic [SECT_W-1:0] sect_addr,
    output logic              cmd_start,
    output logic              cont_pulse,
    output logic              irq
);
    localparam int unsigned CNT_W = DATA_W + DLY_SHIFT;

    regs_t s_d, s_q;
    logic  start_d, start_q;

    logic  rd_isr, rd_sta, rd_stb, wr_cmd;
    logic  wr_busy, wr_xfer, wr_seek;
    logic  dn_busy, dn_xfer, dn_seek;
    logic  [DATA_W-1:0] sta_view;

    assign rd_isr = rd_en && (reg_off_e'(addr) == OFF_CMD);
    assign rd_sta = rd_en && (reg_off_e'(addr) == OFF_SETUP);
    assign rd_stb = rd_en && (reg_off_e'(addr) == OFF_SECT);
    assign wr_cmd = wr_en && (reg_off_e'(addr) == OFF_CMD);

    fdc_cmd_decode i_dec_wr (
        .code      (wdata[3:0]),
        .sets_busy (wr_busy),
        .is_xfer   (wr_xfer),
        .is_seek   (wr_seek)
    );

    fdc_cmd_decode i_dec_done (
        .code      (s_q.cmd[3:0]),
        .sets_busy (dn_busy),
        .is_xfer   (dn_xfer),
        .is_seek   (dn_seek)
    );

    // main status as seen on a read: live drive lines over latched bits
    always_comb begin
        sta_view           = s_q.sta;
        sta_view[STA_RDY]  = drv_ready;
        sta_view[STA_TRK0] = drv_trk0;
        sta_view[STA_WP]   = drv_wprot;
        sta_view[STA_IDX]  = drv_index;
    end

    always_comb begin
        s_d     = s_q;
        start_d = 1'b0;

        // read side effects
        if (rd_isr) s_d.isr[2:0] = '0;
        if (rd_sta) s_d.sta = sta_view;
        if (rd_stb) s_d.stb = s_q.stb & STB_RD_KEEP;

        // register writes
        if (wr_en) begin
            case (reg_off_e'(addr))
                OFF_TRACK: s_d.trk   = wdata[TRK_W-1:0];
                OFF_SETUP: s_d.setup = wdata;
                OFF_SECT:  s_d.sect  = wdata[SECT_W-1:0];
                OFF_COUNT: s_d.cnt   = wdata[TRK_W-1:0];
                OFF_CRC:   s_d.crc   = wdata[CRC_W-1:0];
                OFF_LTRK:  s_d.ltrk  = wdata[TRK_W-1:0];
                OFF_CMD: begin
                    s_d.sta[STA_BUSY] = 1'b0;
                    s_d.sta[STA_DREQ] = 1'b0;
                    if (wr_busy) begin
                        s_d.sta[STA_BUSY] = 1'b1;
                        start_d           = 1'b1;
                    end
                    if (wr_xfer) begin
                        s_d.sta[STA_TNE] = 1'b0;
                        s_d.sta[STA_DDM] = 1'b0;
                        s_d.stb[2]       = 1'b0;
                    end
                    s_d.cmd = wdata;
                end
                default: ;
            endcase
        end

        // command engine events
        s_d.sta = s_d.sta | (eng_sta_set & STA_ENG_MASK);
        s_d.stb = s_d.stb | eng_stb_set;
        if (eng_sense) s_d.isr[2] = 1'b1;
        if (eng_done && !wr_cmd) begin
            if (dn_seek) s_d.isr[1] = 1'b1;
            else         s_d.isr[0] = 1'b1;
            s_d.sta[STA_BUSY] = 1'b0;
            s_d.cmd[3:0]      = 4'h0;
        end

        // controller reset
        if (soft_rst) begin
            s_d.cmd[3:0] = 4'h0;
            s_d.isr      = '0;
            s_d.sect     = '0;
            s_d.sta      = s_q.sta & STA_SRST_KEEP;
            s_d.stb      = s_q.stb & STB_SRST_KEEP;
            start_d      = 1'b0;
        end

        // error summary bit follows error status and its enable
        s_d.isr[3] = (s_d.stb != '0) && !s_d.cmd[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            start_q <= 1'b0;
        end else begin
            s_q     <= s_d;
            start_q <= start_d;
        end
    end

    fdc_delay_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_cmd && wr_busy && !soft_rst),
        .clr   (eng_done || soft_rst),
        .load  ({s_q.setup, {DLY_SHIFT{1'b1}}}),
        .pulse (cont_pulse)
    );

    fdc_irq_gen i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .isr   (s_q.isr),
        .mask  (s_q.cmd[7]),
        .irq   (irq)
    );

    always_comb begin
        case (reg_off_e'(addr))
            OFF_TRACK: rdata = DATA_W'(s_q.trk);
            OFF_CMD:   rdata = DATA_W'(s_q.isr);
            OFF_SETUP: rdata = sta_view;
            OFF_SECT:  rdata = s_q.stb;
            OFF_COUNT: rdata = DATA_W'(s_q.cnt);
            OFF_CRC:   rdata = DATA_W'(s_q.crc);
            OFF_LTRK:  rdata = DATA_W'(s_q.ltrk);
            default:   rdata = '0;
        endcase
    end

    assign sect_addr = s_q.sect;
    assign cmd_start = start_q;

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.isr[3] == ((s_q.stb != '0) && !s_q.cmd[6])); // R2
    AST_ISR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && !eng_sense && !eng_done) |=> (s_q.isr[2:0] == 3'b000)); // R4
    AST_STB_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && eng_stb_set == '0) |=> ((s_q.stb & ~STB_RD_KEEP) == '0)); // R5
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !wr_cmd) |=> !s_q.sta[STA_BUSY]); // R6
    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> s_q.sta[STA_BUSY]); // R7
endmodule

// File: tb/test_fdc_regfile.sv
module test_fdc_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       drv_ready = 1'b0, drv_trk0 = 1'b0, drv_wprot = 1'b0, drv_index = 1'b0;
    logic       eng_sense = 1'b0;
    logic [7:0] eng_sta_set = 8'd0, eng_stb_set = 8'd0;
    logic       eng_done = 1'b0;
    logic [4:0] sect_addr;
    logic       cmd_start, cont_pulse, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fdc_regfile #(.DLY_SHIFT(2)) i_fdc_regfile (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .drv_ready(drv_ready), .drv_trk0(drv_trk0), .drv_wprot(drv_wprot),
        .drv_index(drv_index), .eng_sense(eng_sense), .eng_sta_set(eng_sta_set),
        .eng_stb_set(eng_stb_set), .eng_done(eng_done), .sect_addr(sect_addr),
        .cmd_start(cmd_start), .cont_pulse(cont_pulse), .irq(irq)
    );

    // vector: [27] write, [26:24] offset, [23:16] data, [15:8] expected, [7:0] requirement
    localparam int NVEC = 11;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 3'd1, 8'hFF, 8'h00, 8'd1},
        {1'b0, 3'd1, 8'h00, 8'h7F, 8'd1},
        {1'b1, 3'd5, 8'hAB, 8'h00, 8'd1},
        {1'b0, 3'd5, 8'h00, 8'h2B, 8'd1},
        {1'b1, 3'd7, 8'h80, 8'h00, 8'd1},
        {1'b0, 3'd7, 8'h00, 8'h00, 8'd1},
        {1'b1, 3'd6, 8'hFF, 8'h00, 8'd1},
        {1'b0, 3'd6, 8'h00, 8'h03, 8'd1},
        {1'b1, 3'd7, 8'h55, 8'h00, 8'd1},
        {1'b0, 3'd7, 8'h00, 8'h55, 8'd1},
        {1'b0, 3'd0, 8'h00, 8'h00, 8'd1}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        check8(req, v, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_sets(input logic [7:0] sa, input logic [7:0] sb, input logic sn);
        @(negedge clk); eng_sta_set = sa; eng_stb_set = sb; eng_sense = sn;
        @(negedge clk); eng_sta_set = 8'd0; eng_stb_set = 8'd0; eng_sense = 1'b0;
    endtask

    // called right after bus_wr returns; expects pulse on the n-th following negedge
    task automatic chk_delay(input string req, input int n);
        int early = 0;
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            if (cont_pulse) early++;
        end
        check8({req, " no early pulse"}, 8'(early), 8'd0);
        @(negedge clk);
        check8({req, " pulse at N"}, {7'd0, cont_pulse}, 8'd1);
        @(negedge clk);
        check8({req, " pulse one cycle"}, {7'd0, cont_pulse}, 8'd0);
    endtask

    initial begin
        #(100000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int early;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state (R9 context)
        check8("R9 reset irq", {7'd0, irq}, 8'd0);
        rd_chk("R9 reset isr", 3'd2, 8'h00);
        rd_chk("R9 reset stb", 3'd4, 8'h00);
        check8("R9 reset sect", {3'd0, sect_addr}, 8'h00);

        // R8 live fold of drive lines
        drv_ready = 1'b1; drv_index = 1'b1;
        rd_chk("R8 ready+index", 3'd3, 8'h44);
        drv_ready = 1'b0; drv_index = 1'b0; drv_trk0 = 1'b1; drv_wprot = 1'b1;
        rd_chk("R8 trk0+wprot", 3'd3, 8'h18);
        drv_trk0 = 1'b0; drv_wprot = 1'b0;
        rd_chk("R8 lines low", 3'd3, 8'h00);

        // R1 table of write masks and readback
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][27]) begin
                bus_wr(VEC[i][26:24], VEC[i][23:16]);
            end else begin
                rd_chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), VEC[i][26:24], VEC[i][15:8]);
            end
        end
        bus_wr(3'd4, 8'hFF);
        check8("R1 sector mask", {3'd0, sect_addr}, 8'h1F);

        // seek command, setup 0 -> N = 4
        bus_wr(3'd2, 8'h03);
        check8("R7 cmd_start", {7'd0, cmd_start}, 8'd1);
        chk_delay("R10 N=4", 4);
        rd_chk("R7 busy set", 3'd3, 8'h80);
        pulse_done();
        check8("R3 irq on completion", {7'd0, irq}, 8'd1);
        rd_chk("R6 seek sets bit1", 3'd2, 8'h02);
        check8("R4 irq after isr read", {7'd0, irq}, 8'd0);
        rd_chk("R4 isr cleared", 3'd2, 8'h00);
        rd_chk("R6 busy cleared", 3'd3, 8'h00);
        pulse_done();
        rd_chk("R6 code zeroed -> bit0", 3'd2, 8'h01);

        // error status with summary bit
        bus_wr(3'd2, 8'h04);
        pulse_sets(8'h00, 8'h05, 1'b0);
        check8("R3 irq from summary", {7'd0, irq}, 8'd1);
        rd_chk("R2 summary set", 3'd2, 8'h08);
        rd_chk("R4 bit3 kept", 3'd2, 8'h08);
        rd_chk("R5 stb value", 3'd4, 8'h05);
        rd_chk("R5 only bit2 kept", 3'd4, 8'h04);
        rd_chk("R2 summary with bit2", 3'd2, 8'h08);
        pulse_sets(8'h22, 8'h00, 1'b0);
        rd_chk("R7 flags latched", 3'd3, 8'hA2);
        bus_wr(3'd2, 8'h04);
        rd_chk("R7 xfer clears sta 5,1", 3'd3, 8'h80);
        rd_chk("R7 xfer clears stb 2", 3'd4, 8'h00);
        rd_chk("R2 summary cleared", 3'd2, 8'h00);

        // masking
        bus_wr(3'd2, 8'h84);
        pulse_sets(8'h00, 8'h01, 1'b0);
        check8("R3 masked", {7'd0, irq}, 8'd0);
        pulse_sets(8'h00, 8'h00, 1'b1);
        check8("R3 sense unmaskable", {7'd0, irq}, 8'd1);
        rd_chk("R3 isr sense+summary", 3'd2, 8'h0C);
        check8("R3 masked after read", {7'd0, irq}, 8'd0);
        bus_wr(3'd2, 8'h40);
        rd_chk("R2 bit6 disables summary", 3'd2, 8'h00);
        rd_chk("R7 code0 no busy", 3'd3, 8'h00);
        rd_chk("R5 stb drain", 3'd4, 8'h01);

        // controller reset
        bus_wr(3'd2, 8'h03);
        pulse_sets(8'h23, 8'h21, 1'b0);
        rd_chk("R9 pre sta", 3'd3, 8'hA3);
        bus_wr(3'd4, 8'h0A);
        check8("R9 pre sect", {3'd0, sect_addr}, 8'h0A);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd_chk("R9 sta masked", 3'd3, 8'h00);
        rd_chk("R9 isr cleared", 3'd2, 8'h08);
        check8("R9 sect zeroed", {3'd0, sect_addr}, 8'h00);
        pulse_done();
        rd_chk("R9 code zeroed", 3'd2, 8'h09);
        rd_chk("R9 stb masked", 3'd4, 8'h20);

        // R10 restart and cancel with setup 3 -> N = 16
        bus_wr(3'd3, 8'h03);
        bus_wr(3'd2, 8'h05);
        early = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (cont_pulse) early++;
        end
        bus_wr(3'd2, 8'h05);
        for (int k = 0; k < 1; k++) if (cont_pulse) early++;
        check8("R10 restart no pulse", 8'(early), 8'd0);
        chk_delay("R10 N=16 restart", 16);
        bus_wr(3'd2, 8'h05);
        @(negedge clk);
        pulse_done();
        early = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (cont_pulse) early++;
        end
        check8("R10 cancel by done", 8'(early), 8'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule